// File: doc/BRIEF.md
# Peripheral Select and Poll Responder

This block sits between a host I/O bus and one peripheral interface card. It works out from the host's peripheral address lines when the card is being addressed and produces a registered bus enable and a data direction output for the card's data buffers. The enable is held off while the host runs a poll cycle or is changing select codes. It is also held off unless the card's own device currently owns the select code, which two devices share.

During a poll cycle the block answers on the one data line whose index equals its select code, and only when the attached controller reports ready. Ready status is brought into the bus clock domain through a synchronizer chain. It is then frozen at the first cycle of each poll, so an answer can never appear or disappear part-way through a poll. Interface clear returns all of this logic to idle and gives the shared select code back to device 1.

Top module: `periph_sel_poll`

## Requirements
- R1: While `rst` is high, at the next clock edge `bus_en`, `dir_out` and all bits of `poll_drv` become 0, and the sharing register selects device 1.
- R2: One clock after an edge that samples `addr` equal to 7 (all three bits 1), `poll_n` high, `sc_change` low, `ifc` low and device 1 selected, `bus_en` is 1. Any other address gives `bus_en` 0.
- R3: One clock after an edge that samples `poll_n` low (poll in progress), `bus_en` is 0.
- R4: One clock after an edge that samples `sc_change` high, `bus_en` is 0.
- R5: At each edge where `sc_change` is high, the sharing register loads `share_sel` (0 = device 1, 1 = device 2). `bus_en` can only be 1 while the register holds device 1.
- R6: One clock after an edge that samples `ifc` high, `bus_en`, `dir_out` and `poll_drv` are 0 and the sharing register holds device 1.
- R7: `dir_out` is the value of `host_read` registered at the same edge as `bus_en`, and is 0 whenever that `bus_en` is 0.
- R8: `ready` passes through two flip-flops. At the first edge that samples `poll_n` low after an edge that sampled it high, the synchronized ready is latched. For the rest of that poll, `poll_drv[7]` is that latched value, registered one clock after each sampling edge. `poll_drv[6:0]` are always 0, and `poll_drv` is 0 outside a poll.
- R9: A change of `ready` during a poll does not alter `poll_drv` until the next poll begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Peripheral address from host |
| poll_n | input | 1 | Poll strobe, low during a poll |
| sc_change | input | 1 | High while the host changes select code |
| share_sel | input | 1 | Device chosen during a select-code change: 0 device 1, 1 device 2 |
| host_read | input | 1 | Host transfer direction, 1 = read from card |
| ready | input | 1 | Controller ready status, asynchronous |
| ifc | input | 1 | Interface clear, synchronous, active high |
| bus_en | output | 1 | Registered bus buffer enable |
| dir_out | output | 1 | Registered buffer direction, gated by enable |
| poll_drv | output | 8 | Per-bit drive enables for the poll response |

## Verification
The enable path is tried with random address patterns biased toward the card's own code. These are mixed with polls, select-code changes and ownership flips, so each blocking condition is seen both on its own and together with the others. Directed runs raise ready in the middle of a poll, which separates a correctly frozen answer from one that follows ready directly. They also pulse interface clear while device 2 owns the code, to show that ownership returns to device 1. Bursts of back-to-back polls with ready toggling check that the answer is latched at each poll start, not at the first poll only.

// File: rtl/psp_pkg.sv
package psp_pkg;
  typedef enum logic {
    DEV_PRIMARY   = 1'b0,
    DEV_SECONDARY = 1'b1
  } share_dev_e;
endpackage

// File: rtl/psp_ready_sync.sv
module psp_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/psp_sel_decode.sv
module psp_sel_decode
  import psp_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int SEL_CODE = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              poll_n,
  input  logic              sc_change,
  input  logic              share_sel,
  input  logic              host_read,
  input  logic              ifc,
  output logic              bus_en,
  output logic              dir_out
);
  localparam logic [ADDR_W-1:0] MY_CODE = ADDR_W'(SEL_CODE);

  share_dev_e owner_q;
  logic       en_next;

  assign en_next = (addr == MY_CODE) && poll_n && !sc_change
                   && (owner_q == DEV_PRIMARY);

  always_ff @(posedge clk) begin
    if (rst || ifc) begin
      owner_q <= DEV_PRIMARY;
    end else if (sc_change) begin
      owner_q <= share_dev_e'(share_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ifc) begin
      bus_en  <= 1'b0;
      dir_out <= 1'b0;
    end else begin
      bus_en  <= en_next;
      dir_out <= en_next && host_read;
    end
  end

  AST_POLL_BLOCKS_EN: assert property (@(posedge clk) disable iff (rst)
    !poll_n |=> !bus_en); // R3
  AST_SCC_BLOCKS_EN: assert property (@(posedge clk) disable iff (rst)
    sc_change |=> !bus_en); // R4
  AST_SHARE_BLOCKS_EN: assert property (@(posedge clk) disable iff (rst)
    (owner_q == DEV_SECONDARY && !sc_change && !ifc) |=> !bus_en); // R5
  AST_DIR_GATED: assert property (@(posedge clk) disable iff (rst)
    dir_out |-> bus_en); // R7
endmodule

// File: rtl/psp_poll_resp.sv
module psp_poll_resp #(
  parameter int DATA_W   = 8,
  parameter int SEL_CODE = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_n,
  input  logic              ifc,
  input  logic              rdy_sync,
  output logic [DATA_W-1:0] poll_drv
);
  logic poll_act;
  logic poll_prev_q;
  logic poll_start;
  logic rdy_hold_q;
  logic resp_q;

  assign poll_act   = !poll_n;
  assign poll_start = poll_act && !poll_prev_q;

  // Reset to "poll seen" so a poll already running at reset never starts a reply.
  always_ff @(posedge clk) begin
    if (rst) poll_prev_q <= 1'b1;
    else     poll_prev_q <= poll_act;
  end

  always_ff @(posedge clk) begin
    if (rst || ifc) begin
      rdy_hold_q <= 1'b0;
      resp_q     <= 1'b0;
    end else begin
      if (poll_start) rdy_hold_q <= rdy_sync;
      resp_q <= poll_act && (poll_start ? rdy_sync : rdy_hold_q);
    end
  end

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == SEL_CODE) begin : g_mine
        assign poll_drv[b] = resp_q;
      end else begin : g_other
        assign poll_drv[b] = 1'b0;
      end
    end
  endgenerate

  AST_NO_MIDPOLL_START: assert property (@(posedge clk) disable iff (rst)
    $rose(resp_q) |-> ($past(poll_n, 2) && !$past(poll_n, 1))); // R8
  AST_HOLD_DURING_POLL: assert property (@(posedge clk) disable iff (rst || ifc)
    (poll_act && poll_prev_q && resp_q) |=> resp_q); // R9
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    poll_n |=> !resp_q); // R8
endmodule

// File: rtl/periph_sel_poll.sv
module periph_sel_poll #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SEL_CODE    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              poll_n,
  input  logic              sc_change,
  input  logic              share_sel,
  input  logic              host_read,
  input  logic              ready,
  input  logic              ifc,
  output logic              bus_en,
  output logic              dir_out,
  output logic [DATA_W-1:0] poll_drv
);
  logic rdy_s;

  psp_sel_decode #(.ADDR_W(ADDR_W), .SEL_CODE(SEL_CODE)) u_dec (
    .clk(clk), .rst(rst), .addr(addr), .poll_n(poll_n),
    .sc_change(sc_change), .share_sel(share_sel), .host_read(host_read),
    .ifc(ifc), .bus_en(bus_en), .dir_out(dir_out)
  );

  psp_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(ready), .d_sync(rdy_s)
  );

  psp_poll_resp #(.DATA_W(DATA_W), .SEL_CODE(SEL_CODE)) u_poll (
    .clk(clk), .rst(rst), .poll_n(poll_n), .ifc(ifc),
    .rdy_sync(rdy_s), .poll_drv(poll_drv)
  );

  AST_IFC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ifc |=> (!bus_en && !dir_out && poll_drv == '0)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!bus_en && !dir_out && poll_drv == '0)); // R1
endmodule

// File: tb/tb_periph_sel_poll.sv
module tb_periph_sel_poll;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = 3'd0;
  logic       poll_n = 1'b1, sc_change = 1'b0, share_sel = 1'b0;
  logic       host_read = 1'b0, ready = 1'b0, ifc = 1'b0;
  logic       bus_en, dir_out;
  logic [7:0] poll_drv;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string phase = "";

  always #10 clk = ~clk;

  periph_sel_poll dut (
    .clk(clk), .rst(rst), .addr(addr), .poll_n(poll_n), .sc_change(sc_change),
    .share_sel(share_sel), .host_read(host_read), .ready(ready), .ifc(ifc),
    .bus_en(bus_en), .dir_out(dir_out), .poll_drv(poll_drv)
  );

  // Reference model, advanced on every rising edge from the sampled inputs.
  logic m_en, m_dir, m_dev1, m_s1, m_s2, m_pd, m_lat, m_r7;
  string en_tag;

  function automatic string en_reason(logic pn, logic scc, logic dev1);
    if (!pn) return "R3";
    if (scc) return "R4";
    if (!dev1) return "R5";
    return "R2";
  endfunction

  always @(posedge clk) begin
    logic pa, st, nen;
    pa  = !poll_n;
    st  = pa && !m_pd;
    nen = (addr == 3'd7) && poll_n && !sc_change && m_dev1;
    en_tag = en_reason(poll_n, sc_change, m_dev1);
    if (rst) begin
      m_en = 0; m_dir = 0; m_r7 = 0; m_dev1 = 1; m_s1 = 0; m_s2 = 0;
      m_pd = 1; m_lat = 0; en_tag = "R1";
    end else begin
      if (ifc) begin
        m_en = 0; m_dir = 0; m_r7 = 0; m_lat = 0; m_dev1 = 1; en_tag = "R6";
      end else begin
        m_en  = nen;
        m_dir = nen && host_read;
        m_r7  = pa && (st ? m_s2 : m_lat);
        if (st) m_lat = m_s2;
        if (sc_change) m_dev1 = !share_sel;
      end
      m_pd = pa;
      m_s2 = m_s1;
      m_s1 = ready;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check((phase != "") ? phase : en_tag, {7'd0, bus_en}, {7'd0, m_en});
    check((phase != "") ? phase : "R7", {7'd0, dir_out}, {7'd0, m_dir});
    check((phase != "") ? phase : "R8", poll_drv, {m_r7, 7'd0});
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    phase = "R1"; compare_all();
    rst = 1'b0;

    // R2: own address with idle poll
    addr = 3'd7; host_read = 1'b1; phase = "R2"; step();
    addr = 3'd5; step(); phase = "";

    // R9: ready rises in the middle of a poll, answer deferred
    addr = 3'd7; ready = 1'b0; poll_n = 1'b1; step(); step(); step();
    phase = "R9"; poll_n = 1'b0; step(); step();
    ready = 1'b1;
    for (int i = 0; i < 5; i++) step();
    poll_n = 1'b1; step(); step();
    poll_n = 1'b0; step(); step(); step();
    poll_n = 1'b1; step(); phase = "";

    // R6: hand code to device 2, then interface clear returns it to device 1
    sc_change = 1'b1; share_sel = 1'b1; phase = "R5"; step();
    sc_change = 1'b0; step(); step();
    ifc = 1'b1; phase = "R6"; step();
    ifc = 1'b0; step(); step(); phase = "";

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      addr      = ($urandom_range(0, 9) < 7) ? 3'd7 : 3'($urandom_range(0, 7));
      poll_n    = ($urandom_range(0, 9) >= 3);
      sc_change = ($urandom_range(0, 19) == 0);
      share_sel = ($urandom_range(0, 2) == 0);
      host_read = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) ready = ~ready;
      ifc       = ($urandom_range(0, 49) == 0);
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule